// File: doc/BRIEF.md
# Omission-Tolerant Pulse Resynchronization Selector

This block restarts a node's logical clock once per round. It uses resynchronization pulses from the nodes of a replicated system. Each of the N nodes raises a pulse on its own line when its clock reaches the round instant R. The block does four things. It brings each line into the local clock domain and catches the first rising edge. It stamps that edge with the logical-clock value. It discards edges that fall outside an acceptance window of plus or minus W around R. It keeps the accepted stamps in arrival order. Up to F of the N nodes (F < N/2) may stay silent or arrive out of the window.

The window closes when the logical clock reaches R+W+1. At that point f, the number of missing pulses, is known. The block forms two candidate start times:
- the last accepted arrival plus D, which is the (N-f)th pulse;
- the (F-f+1)th accepted arrival plus 2D.

The new clock starts at the earlier of the two, with a tie going to the D candidate. Two down-counters time the candidates. Both are loaded at window close with an offset of LAT = 2W+2 cycles. The strobe therefore fires LAT cycles after the chosen start time, and the logical clock is reloaded with LAT, so its reading stays correct. A round is declared faulty in either of two cases: fewer than N-F pulses were accepted, or the spread between the two order-statistic arrivals reaches 2D. A faulty round raises the fault flag and restarts on the block's own schedule, at start time R+D.

Top module: `resync_selector`

## Requirements
- R1: In reset, lclk_o, restart_o, cand_b_o and fault_o are 0. After reset, lclk_o rises by one every cycle until a restart.
- R2: A line raised high is first sampled at some edge. lclk_o holds value x in the cycle just before that edge. The arrival is stamped x+2, after two synchronizer stages and a rising-edge detector.
- R3: A pulse is accepted only if its stamp lies in [R-W, R+W], with both ends included. Other pulses are ignored.
- R4: Only the first accepted rising edge of each line counts within a round. Later edges on that line are ignored until the next restart.
- R5: Let k ≥ N-F pulses be accepted, sorted ascending as s[0..k-1]. The candidates are TA = s[k-1]+D and TB = s[F-N+k]+2D. The start time is T = min(TA, TB), and TA wins a tie.
- R6: restart_o is high for exactly one cycle, the cycle where lclk_o equals T+LAT with LAT = 2W+2. In the next cycle lclk_o equals LAT.
- R7: cand_b_o is high together with restart_o exactly when TB < TA. It is low on a tie.
- R8: If fewer than N-F pulses are accepted, fault_o is 1 during the restart and T = R+D.
- R9: With at least N-F pulses, s[k-1] - s[F-N+k] ≥ 2D is a spread violation. It is treated like R8: fault_o is 1 and T = R+D.
- R10: fault_o changes only at window close, when lclk_o is R+W+1, and holds until the next close. A round with no violation clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pulse_i | input | N | One asynchronous resync line per node |
| lclk_o | output | CLK_W | Logical clock reading |
| restart_o | output | 1 | One-cycle strobe when the logical clock is reloaded |
| cand_b_o | output | 1 | With restart_o: the 2D candidate was chosen |
| fault_o | output | 1 | Last round too short or too spread; own-schedule restart |

## Verification
The stimulus patterns are as follows:
- Simultaneous arrivals: both candidates coincide in their order statistic, so the D candidate must win.
- A tight spread and a spread wider than D: these separate the D candidate from the 2D candidate.
- One and two silent nodes: these show that both order-statistic indices shift with f.
- A spread of exactly D: this pins down the tie rule.
- Exactly N-F-1 arrivals, and arrivals at 2D spread: these trigger the own-schedule fault path.
- A clean round after a fault: this shows that the flag clears.
- Stamps just inside and just outside the window edges, pulses far before and after the window, and a repeated pulse on one line while another line is silent: these produce distinct start times if window bounds or duplicate filtering are wrong.

// File: rtl/resync_pkg.sv
// Package: shared types of the resynchronization selector.
// Assumes: nothing beyond IEEE 1800-2017.
package resync_pkg;
    typedef enum logic {
        PH_COLLECT = 1'b0,  // window not yet closed, pulses being gathered
        PH_ARMED   = 1'b1   // candidates fixed, delay counters running
    } phase_t;
endpackage

// File: rtl/pulse_edge_capture.sv
// Module: pulse_edge_capture
// Brings each asynchronous resync line through two flip-flops and flags a
// one-cycle rising edge from the third stage.
// Assumes: each pulse stays high for at least two clock cycles.
module pulse_edge_capture #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] line_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] meta_q;
    logic [N-1:0] sync_q;
    logic [N-1:0] prev_q;

    for (genvar g = 0; g < N; g++) begin : g_line
        // Two-stage synchronizer plus delay stage for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q[g] <= 1'b0;
                sync_q[g] <= 1'b0;
                prev_q[g] <= 1'b0;
            end else begin
                meta_q[g] <= line_i[g];
                sync_q[g] <= meta_q[g];
                prev_q[g] <= sync_q[g];
            end
        end
        // Rising edge seen at the synchronized output.
        assign rise_o[g] = sync_q[g] & ~prev_q[g];
    end
endmodule

// File: rtl/arrival_recorder.sv
// Module: arrival_recorder
// Accepts the first edge per line while the window is open, counts accepted
// pulses and stores their stamps in arrival order (slot 0 = earliest).
// Assumes: clear_i pulses once per round at the restart.
module arrival_recorder #(
    parameter int N     = 5,
    parameter int CLK_W = 12,
    parameter int CNT_W = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear_i,
    input  logic                      open_i,
    input  logic [N-1:0]              rise_i,
    input  logic [CLK_W-1:0]          stamp_i,
    output logic [CNT_W-1:0]          count_o,
    output logic [N-1:0][CLK_W-1:0]   times_o
);
    logic [N-1:0]     seen_q;
    logic [N-1:0]     take;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W:0]   lo_w;
    logic [CNT_W:0]   hi_w;

    // Count set bits of a line mask.
    function automatic logic [CNT_W-1:0] ones(input logic [N-1:0] v);
        logic [CNT_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < N; i++) acc = acc + CNT_W'(v[i]);
        return acc;
    endfunction

    // New accepted edges this cycle: window open and line not yet seen.
    assign take = rise_i & ~seen_q & {N{open_i}};
    assign lo_w = {1'b0, count_q};
    assign hi_w = {1'b0, count_q} + {1'b0, ones(take)};

    // Per-line acceptance mask and accepted-pulse counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            seen_q  <= '0;
            count_q <= '0;
        end else begin
            seen_q  <= seen_q | take;
            count_q <= hi_w[CNT_W-1:0];
        end
    end

    for (genvar j = 0; j < N; j++) begin : g_slot
        // Slot j receives the stamp when it falls inside this cycle's new range.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                times_o[j] <= '0;
            end else if (!clear_i && (CNT_W+1)'(j) >= lo_w && (CNT_W+1)'(j) < hi_w) begin
                times_o[j] <= stamp_i;
            end
        end
    end

    assign count_o = count_q;

    // R4
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(N));
    // R4
    count_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> count_q >= $past(count_q));
endmodule

// File: rtl/delay_timer.sv
// Module: delay_timer
// Down-counter loaded with a delay; expire_o is high while it sits at zero.
// Assumes: clear_i stops it after expiry is consumed.
module delay_timer #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         clear_i,
    output logic         expire_o
);
    logic         run_q;
    logic [W-1:0] cnt_q;

    // Load, count down to zero, stop on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (load_i) begin
            run_q <= 1'b1;
            cnt_q <= load_val_i;
        end else if (run_q && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire_o = run_q && (cnt_q == '0);

    // R6
    expire_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o && !clear_i && !load_i |=> expire_o);
endmodule

// File: rtl/resync_selector.sv
// Module: resync_selector (top)
// Runs the logical clock, opens the acceptance window around R, and at window
// close fixes the two order-statistic candidates (last pulse + D, pulse
// F-f+1 + 2D). It loads two delay timers offset by LAT and strobes a restart
// when the first expires, reloading the clock with LAT.
// Assumes: 2F < N, D >= 1, R > 3W+2, and R+W+D+LAT fits in CLK_W bits.
module resync_selector #(
    parameter int N     = 5,
    parameter int F     = 2,
    parameter int CLK_W = 12,
    parameter int R_INS = 200,
    parameter int WIN   = 12,
    parameter int DLY   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     pulse_i,
    output logic [CLK_W-1:0] lclk_o,
    output logic             restart_o,
    output logic             cand_b_o,
    output logic             fault_o
);
    import resync_pkg::*;

    localparam int CNT_W = $clog2(N + 1);
    localparam int TMR_W = CLK_W + 2;
    localparam int LAT   = 2 * WIN + 2;
    localparam logic [CLK_W-1:0] WIN_LO  = CLK_W'(R_INS - WIN);
    localparam logic [CLK_W-1:0] WIN_HI  = CLK_W'(R_INS + WIN);
    localparam logic [CLK_W-1:0] CLOSE_T = CLK_W'(R_INS + WIN + 1);
    localparam logic [CLK_W-1:0] LAT_C   = CLK_W'(LAT);
    localparam logic [CLK_W-1:0] EARLY_C = CLK_W'(R_INS - WIN + DLY + LAT);
    localparam logic [CNT_W-1:0] NEED_C  = CNT_W'(N - F);
    localparam logic [TMR_W-1:0] D_T     = TMR_W'(DLY);
    localparam logic [TMR_W-1:0] D2_T    = TMR_W'(2 * DLY);
    localparam logic [TMR_W-1:0] OFS_T   = TMR_W'(R_INS - WIN);
    localparam logic [TMR_W-1:0] OWN_T   = TMR_W'(DLY + WIN);

    phase_t                    phase_q;
    logic [CLK_W-1:0]          lclk_q;
    logic                      fault_q;
    logic [N-1:0]              rise;
    logic                      open_w;
    logic                      close_w;
    logic                      restart_w;
    logic                      exp_a;
    logic                      exp_b;
    logic [CNT_W-1:0]          count_w;
    logic [N-1:0][CLK_W-1:0]   times_w;
    logic [CNT_W-1:0]          idx_a;
    logic [CNT_W-1:0]          idx_b;
    logic [TMR_W-1:0]          t_a;
    logic [TMR_W-1:0]          t_b;
    logic                      short_w;
    logic                      spread_w;
    logic                      bad_w;
    logic [TMR_W-1:0]          load_a;
    logic [TMR_W-1:0]          load_b;

    pulse_edge_capture #(.N(N)) cap_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (pulse_i),
        .rise_o (rise)
    );

    arrival_recorder #(.N(N), .CLK_W(CLK_W), .CNT_W(CNT_W)) rec_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (restart_w),
        .open_i  (open_w),
        .rise_i  (rise),
        .stamp_i (lclk_q),
        .count_o (count_w),
        .times_o (times_w)
    );

    // Window and close decode from phase and clock reading.
    assign open_w  = (phase_q == PH_COLLECT) && (lclk_q >= WIN_LO) && (lclk_q <= WIN_HI);
    assign close_w = (phase_q == PH_COLLECT) && (lclk_q == CLOSE_T);

    // Order-statistic indices: last accepted and (F-f+1)th accepted.
    assign short_w = count_w < NEED_C;
    assign idx_a   = (count_w == '0) ? '0 : count_w - 1'b1;
    assign idx_b   = short_w ? '0 : count_w - NEED_C;
    assign t_a     = TMR_W'(times_w[idx_a]);
    assign t_b     = TMR_W'(times_w[idx_b]);

    // Spread check and timer load values (target + W - R, the LAT offset).
    assign spread_w = !short_w && ((t_a - t_b) >= D2_T);
    assign bad_w    = short_w || spread_w;
    assign load_a   = bad_w ? OWN_T : (t_a + D_T - OFS_T);
    assign load_b   = t_b + D2_T - OFS_T;

    delay_timer #(.W(TMR_W)) tmr_a_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (close_w),
        .load_val_i (load_a),
        .clear_i    (restart_w),
        .expire_o   (exp_a)
    );

    delay_timer #(.W(TMR_W)) tmr_b_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (close_w && !bad_w),
        .load_val_i (load_b),
        .clear_i    (restart_w),
        .expire_o   (exp_b)
    );

    assign restart_w = (phase_q == PH_ARMED) && (exp_a || exp_b);

    // Logical clock: count up, reload with LAT on restart.
    always_ff @(posedge clk) begin
        if (!rst_n)         lclk_q <= '0;
        else if (restart_w) lclk_q <= LAT_C;
        else                lclk_q <= lclk_q + 1'b1;
    end

    // Round phase: armed at window close, back to collecting on restart.
    always_ff @(posedge clk) begin
        if (!rst_n)         phase_q <= PH_COLLECT;
        else if (close_w)   phase_q <= PH_ARMED;
        else if (restart_w) phase_q <= PH_COLLECT;
    end

    // Fault flag: decided once per round at window close.
    always_ff @(posedge clk) begin
        if (!rst_n)       fault_q <= 1'b0;
        else if (close_w) fault_q <= bad_w;
    end

    assign lclk_o    = lclk_q;
    assign restart_o = restart_w;
    assign cand_b_o  = restart_w && exp_b && !exp_a;
    assign fault_o   = fault_q;

    // R6
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |=> lclk_o == LAT_C);
    // R6
    strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |=> !restart_o);
    // R6
    earliest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |-> lclk_o >= EARLY_C);
    // R10
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q == PH_ARMED |=> $stable(fault_q));
endmodule

// File: tb/resync_selector_tb.sv
// Bench: scoreboard. The driver task computes each round's expected restart
// from the requirements and queues it; the monitor pops on every strobe.
`timescale 1ns/1ps
module resync_selector_tb_top;
    localparam int N = 5;
    localparam int F = 2;
    localparam int CLK_W = 12;
    localparam int R_INS = 200;
    localparam int WIN = 12;
    localparam int DLY = 8;
    localparam int LAT = 2 * WIN + 2;

    typedef struct {
        int    fire;
        bit    fault;
        bit    candb;
        string tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N-1:0]     pulse_i = '0;
    logic [CLK_W-1:0] lclk_o;
    logic             restart_o;
    logic             cand_b_o;
    logic             fault_o;

    int   checks = 0;
    int   errors = 0;
    bit   chk_reload = 1'b0;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    resync_selector #(.N(N), .F(F), .CLK_W(CLK_W), .R_INS(R_INS), .WIN(WIN), .DLY(DLY)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pulse_i   (pulse_i),
        .lclk_o    (lclk_o),
        .restart_o (restart_o),
        .cand_b_o  (cand_b_o),
        .fault_o   (fault_o)
    );

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Monitor: compare every strobe against the next queued expectation.
    always @(negedge clk) begin
        if (chk_reload) begin
            check("R6 reload value", int'(lclk_o), LAT);
            chk_reload = 1'b0;
        end
        if (rst_n && restart_o) begin
            if (sb_q.size() == 0) begin
                check("R6 unexpected restart", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check({"R6 fire time ", e.tag}, int'(lclk_o), e.fire);
                check({"R7 candidate ", e.tag}, int'(cand_b_o), int'(e.candb));
                check({"R8/R9/R10 fault ", e.tag}, int'(fault_o), int'(e.fault));
                chk_reload = 1'b1;
            end
        end
    end

    function automatic bit in_win(input int s);
        return (s >= R_INS - WIN) && (s <= R_INS + WIN);
    endfunction

    // Driver: compute expected (R3, R4, R5, R8, R9), queue it, drive the lines.
    task automatic run_round(input int s1[N], input int s2[N], input string tag);
        int   v[N];
        int   k;
        int   ta, tb, tgt;
        bit   flt, cb;
        exp_t e;
        k = 0;
        for (int n = 0; n < N; n++) begin
            if (s1[n] >= 0 && in_win(s1[n]))      begin v[k] = s1[n]; k++; end
            else if (s2[n] >= 0 && in_win(s2[n])) begin v[k] = s2[n]; k++; end
        end
        for (int a = 0; a < k; a++)
            for (int b = 0; b + 1 < k - a; b++)
                if (v[b] > v[b+1]) begin int t; t = v[b]; v[b] = v[b+1]; v[b+1] = t; end
        flt = 1'b0; cb = 1'b0; tgt = R_INS + DLY;
        if (k < N - F) begin
            flt = 1'b1;
        end else begin
            ta = v[k-1];
            tb = v[F - N + k];
            if (ta - tb >= 2 * DLY) begin
                flt = 1'b1;
            end else begin
                cb  = (tb + 2 * DLY) < (ta + DLY);
                tgt = cb ? tb + 2 * DLY : ta + DLY;
            end
        end
        e.fire = tgt + LAT; e.fault = flt; e.candb = cb; e.tag = tag;
        sb_q.push_back(e);
        forever begin
            int lc;
            @(negedge clk);
            if (restart_o) break;
            lc = int'(lclk_o);
            for (int n = 0; n < N; n++) begin
                if (s1[n] >= 0 && lc == s1[n] - 2) pulse_i[n] = 1'b1;
                if (s1[n] >= 0 && lc == s1[n] + 1) pulse_i[n] = 1'b0;
                if (s2[n] >= 0 && lc == s2[n] - 2) pulse_i[n] = 1'b1;
                if (s2[n] >= 0 && lc == s2[n] + 1) pulse_i[n] = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int l0;
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 lclk in reset", int'(lclk_o), 0);
        check("R1 restart in reset", int'(restart_o), 0);
        check("R1 cand_b in reset", int'(cand_b_o), 0);
        check("R1 fault in reset", int'(fault_o), 0);
        rst_n = 1'b1;
        @(negedge clk); l0 = int'(lclk_o);
        @(negedge clk);
        check("R1 counting", int'(lclk_o), l0 + 1);

        // R2 R5: all together, D candidate
        run_round('{200, 200, 200, 200, 200}, '{-1, -1, -1, -1, -1}, "R5 aligned");
        // R5 tight spread, D candidate
        run_round('{196, 198, 200, 202, 204}, '{-1, -1, -1, -1, -1}, "R5 tight");
        // R7 spread above D, 2D candidate wins
        run_round('{190, 191, 192, 200, 203}, '{-1, -1, -1, -1, -1}, "R7 wide");
        // R5 one silent node (f=1)
        run_round('{195, 196, -1, 197, 205}, '{-1, -1, -1, -1, -1}, "R5 f1");
        // R5 two silent nodes (f=2)
        run_round('{200, -1, 201, -1, 209}, '{-1, -1, -1, -1, -1}, "R5 f2");
        // R7 tie at spread D goes to D candidate
        run_round('{192, 192, 192, 200, 200}, '{-1, -1, -1, -1, -1}, "R7 tie");
        // R8 too few pulses
        run_round('{200, -1, 203, -1, -1}, '{-1, -1, -1, -1, -1}, "R8 short");
        // R10 clean round clears the flag
        run_round('{200, 200, 200, 200, 200}, '{-1, -1, -1, -1, -1}, "R10 clear");
        // R9 spread at or above 2D
        run_round('{188, 189, 190, 205, 210}, '{-1, -1, -1, -1, -1}, "R9 spread");
        // R3 pulses far before and after the window
        run_round('{150, 200, 200, 200, 220}, '{-1, -1, -1, -1, -1}, "R3 outside");
        // R3 window edges: 188 and 212 in, 187 out
        run_round('{188, 212, 200, 200, 187}, '{-1, -1, -1, -1, -1}, "R3 edges");
        // R4 duplicate edge on node 0 ignored while node 1 is silent
        run_round('{195, -1, 200, 200, 200}, '{207, -1, -1, -1, -1}, "R4 duplicate");

        repeat (4) @(negedge clk);
        check("R6 queue drained", sb_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule